// File: doc/BRIEF.md
# SDRAM Clock-Enable Low-Power State Controller

This block sits in the SDRAM device model next to the command decoder. It watches the clock-enable pin and picks the low-power state the device takes when that pin goes low. The choice depends on the status flags at that moment:

- a burst in flight gives clock suspend;
- an open row gives active power-down;
- an idle array gives either self refresh (when the decoder asks for it) or precharge power-down.

While the device is in clock suspend, the block raises a freeze signal. The burst address counter and the data output registers hold on that signal.

The clock enable is registered once. That registered copy drives every entry decision and the exit from clock suspend. In power-down and self refresh the clock input is assumed gated, so the pin is watched directly, without the register. Exit from those states therefore happens on the first edge that sees the pin high. If the pin is tied high, the block never leaves normal operation.

Top module: `sdr_pwr_ctrl`

## Requirements
- R1: After reset, pwr_state is 0 (normal run) and freeze is 0.
- R2: The clock enable is registered once. A low pin sampled at one rising edge changes pwr_state on the following rising edge, and not before. While the pin stays high, pwr_state stays 0 whatever the flags are.
- R3: On entry, burst_busy high selects clock suspend (pwr_state 3). This case takes priority over all others.
- R4: On entry with no burst and no open row, sref_req high together with banks_idle high selects self refresh (pwr_state 4). Self refresh is never entered while banks_idle is low.
- R5: On entry with no burst, no open row and no self-refresh selection, the state is precharge power-down (pwr_state 1).
- R6: On entry with no burst and row_open high, the state is active power-down (pwr_state 2).
- R7: Once in a low-power state, changes on banks_idle, row_open, burst_busy and sref_req have no effect while the clock enable stays low.
- R8: From power-down (1 or 2) or self refresh (4), pwr_state returns to 0 on the first rising edge at which the clock-enable pin is high.
- R9: From clock suspend, pwr_state returns to 0 on the second rising edge after the pin returns high, because this exit goes through the register.
- R10: freeze is 1 exactly while pwr_state is 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Device clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cke_pin | input | 1 | Clock-enable pin, high = clock active |
| banks_idle | input | 1 | All banks precharged |
| row_open | input | 1 | At least one bank has an open row |
| burst_busy | input | 1 | A read or write burst is running |
| sref_req | input | 1 | Self-refresh request from the command decoder |
| pwr_state | output | 3 | 0 run, 1 precharge power-down, 2 active power-down, 3 clock suspend, 4 self refresh |
| freeze | output | 1 | Holds the burst counter and output registers |

## Verification
A wrong entry decision appears on pwr_state two edges after the pin falls. A wrong state also leaves freeze wrong in that same cycle, so a frozen or running burst is exposed at once. A broken register path shows up at the exits: power-down exits one edge late, or suspend exits one edge early, within two edges of the pin rising. The sweep enters the controller with every flag combination, flips the flags while it is parked, and times both kinds of exit.

// File: rtl/sdr_pwr_pkg.sv
package sdr_pwr_pkg;
  localparam int STATE_W = 3;

  typedef enum logic [STATE_W-1:0] {
    PS_RUN     = 3'd0,
    PS_PRE_PD  = 3'd1,
    PS_ACT_PD  = 3'd2,
    PS_SUSPEND = 3'd3,
    PS_SELFREF = 3'd4
  } pwr_state_e;
endpackage

// File: rtl/cke_sampler.sv
module cke_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic cke_pin,
  output logic cke_q
);
  // single capture stage; reset value is "clock active"
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cke_q <= 1'b1;
    else        cke_q <= cke_pin;
  end
endmodule

// File: rtl/pwr_state_fsm.sv
module pwr_state_fsm
  import sdr_pwr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cke_pin,
  input  logic       cke_q,
  input  logic       banks_idle,
  input  logic       row_open,
  input  logic       burst_busy,
  input  logic       sref_req,
  output pwr_state_e state
);
  pwr_state_e nxt;
  logic       pick_sref;

  assign pick_sref = sref_req && banks_idle;

  always_comb begin
    nxt = state;
    unique case (state)
      PS_RUN: begin
        if (!cke_q) begin
          if (burst_busy)     nxt = PS_SUSPEND;
          else if (row_open)  nxt = PS_ACT_PD;
          else if (pick_sref) nxt = PS_SELFREF;
          else                nxt = PS_PRE_PD;
        end
      end
      PS_PRE_PD, PS_ACT_PD, PS_SELFREF: begin
        // clock gated: pin watched without the capture stage
        if (cke_pin) nxt = PS_RUN;
      end
      PS_SUSPEND: begin
        if (cke_q) nxt = PS_RUN;
      end
      default: nxt = PS_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= PS_RUN;
    else        state <= nxt;
  end

  // R2: a registered-high enable keeps the device running
  a_r2_stay_run: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PS_RUN && cke_q) |=> state == PS_RUN);
  // R4: no self refresh from a non-idle array
  a_r4_sref_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PS_RUN && !banks_idle) |=> state != PS_SELFREF);
  // R7: power-down held while the pin is low
  a_r7_hold_pd: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == PS_PRE_PD || state == PS_ACT_PD) && !cke_pin) |=> $stable(state));
  // R8: fast exit from gated-clock states
  a_r8_fast_exit: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == PS_PRE_PD || state == PS_ACT_PD || state == PS_SELFREF) && cke_pin)
      |=> state == PS_RUN);
  // R9: suspend holds until the registered enable is high
  a_r9_hold_susp: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PS_SUSPEND && !cke_q) |=> state == PS_SUSPEND);
endmodule

// File: rtl/sdr_pwr_ctrl.sv
module sdr_pwr_ctrl
  import sdr_pwr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cke_pin,
  input  logic               banks_idle,
  input  logic               row_open,
  input  logic               burst_busy,
  input  logic               sref_req,
  output logic [STATE_W-1:0] pwr_state,
  output logic               freeze
);
  logic       cke_q;
  pwr_state_e state;

  cke_sampler u_smp (
    .clk     (clk),
    .rst_n   (rst_n),
    .cke_pin (cke_pin),
    .cke_q   (cke_q)
  );

  pwr_state_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .cke_pin    (cke_pin),
    .cke_q      (cke_q),
    .banks_idle (banks_idle),
    .row_open   (row_open),
    .burst_busy (burst_busy),
    .sref_req   (sref_req),
    .state      (state)
  );

  assign pwr_state = state;
  assign freeze    = (state == PS_SUSPEND);

  // R10: freeze lasts while the registered enable is low in suspend
  a_r10_freeze_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && !cke_q) |=> freeze);
endmodule

// File: tb/sim_sdr_pwr_ctrl.sv
module sim_sdr_pwr_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cke_pin = 1'b1;
  logic       banks_idle = 1'b1, row_open = 1'b0, burst_busy = 1'b0, sref_req = 1'b0;
  logic [2:0] pwr_state;
  logic       freeze;
  int         checks = 0, errors = 0;
  bit         done = 0;

  always #5 clk = ~clk;

  sdr_pwr_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cke_pin(cke_pin), .banks_idle(banks_idle),
    .row_open(row_open), .burst_busy(burst_busy), .sref_req(sref_req),
    .pwr_state(pwr_state), .freeze(freeze)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [2:0] exp_st);
    checks++;
    if (pwr_state !== exp_st || freeze !== (exp_st == 3'd3)) begin
      errors++;
      $display("FAIL %s: state=%0d freeze=%0d expected state=%0d freeze=%0d",
               req, pwr_state, freeze, exp_st, exp_st == 3'd3);
    end
  endtask

  function automatic logic [2:0] expect_entry(input logic [3:0] f);
    // f = {sref_req, burst_busy, row_open, banks_idle}
    if (f[2])              return 3'd3;
    else if (f[1])         return 3'd2;
    else if (f[3] && f[0]) return 3'd4;
    else                   return 3'd1;
  endfunction

  function automatic string tag_of(input logic [2:0] s);
    case (s)
      3'd3:    return "R3";
      3'd4:    return "R4";
      3'd1:    return "R5";
      default: return "R6";
    endcase
  endfunction

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: state=%0d expected run to end", pwr_state);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    chk("R1 reset", 3'd0);
    rst_n = 1'b1;
    step();
    chk("R1 after release", 3'd0);

    // R2: pin held high, flags swept every cycle
    for (int i = 0; i < 64; i++) begin
      {sref_req, burst_busy, row_open, banks_idle} = 4'(i);
      step();
      chk("R2 pin high", 3'd0);
    end

    for (int c = 0; c < 16; c++) begin
      logic [2:0] exp_st;
      {sref_req, burst_busy, row_open, banks_idle} = 4'(c);
      exp_st = expect_entry(4'(c));
      cke_pin = 1'b0;
      step();
      chk("R2 entry latency", 3'd0);
      step();
      chk(tag_of(exp_st), exp_st);
      // R7: flip all flags while parked
      {sref_req, burst_busy, row_open, banks_idle} = ~4'(c);
      step();
      chk("R7 flags ignored", exp_st);
      step();
      chk("R7 flags ignored", exp_st);
      cke_pin = 1'b1;
      step();
      if (exp_st == 3'd3) begin
        chk("R9 suspend still held", 3'd3);
        step();
        chk("R9 suspend exit", 3'd0);
      end else begin
        chk("R8 fast exit", 3'd0);
        step();
        chk("R8 stays run", 3'd0);
      end
      chk("R10 freeze low in run", 3'd0);
    end

    // R4: a self-refresh request with a non-idle array gives precharge power-down
    {sref_req, burst_busy, row_open, banks_idle} = 4'b1000;
    cke_pin = 1'b0;
    step();
    step();
    chk("R4 no sref without idle", 3'd1);
    cke_pin = 1'b1;
    step();
    chk("R8 fast exit", 3'd0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule